// File: doc/BRIEF.md
# PS/2 Device Frame Transmitter

This block sits at the device end of a two-wire keyboard or mouse link. Both wires are open-drain with pull-ups. The block only ever pulls a wire low or lets it go, and both wires high means the bus is idle. The block takes one byte at a time from a chunk queue through a valid/ready handshake. It produces the bus clock itself and shifts the byte out as an 11-bit frame:

- a start bit of 0
- eight data bits, least significant first
- an odd parity bit
- a stop bit of 1

The host may clamp the clock wire low at any moment. The block sees this when it releases its clock and the wire does not rise. How it reacts depends on where the frame has reached:

- **Before the first falling edge:** the block keeps the byte and starts again once the wire has been high long enough.
- **After at least one falling edge:** the block drops both wires and pulses an abort strobe, which tells the queue to send the whole chunk again.
- **After the eleventh falling edge:** the frame counts as delivered.

All timings are set in microseconds, scaled by a count of system-clock cycles per microsecond.

Top module: `ps2_dev_tx`

## Requirements
- R1: After reset both open-drain enables are 0 (both wires released), `tx_ready` is 1, and neither strobe is asserted.
- R2: A frame does not begin until the clock wire has been seen high continuously for GUARD_US ticks. A low seen during that wait restarts the wait. The first falling edge comes GUARD_US + HALF_US ticks (plus up to 4 cycles of input synchronisation) after the host releases the wire.
- R3: Each generated low phase lasts exactly HALF_US ticks. Each high phase between two pulses also lasts exactly HALF_US ticks.
- R4: The data wire changes only while the clock wire is high, exactly DATA_US ticks after the clock's rising edge. It stays stable through each low phase.
- R5: The bit seen on the data wire at the n-th falling clock edge is bit n of the frame: the start bit 0, then data[0] to data[7], then parity (1 when the byte has an even number of ones), then the stop bit 1.
- R6: When the low phase of the eleventh pulse ends, `frame_done` pulses for one cycle, both wires are released and `tx_ready` returns to 1. `frame_done` and `frame_abort` are never asserted together.
- R7: A clock wire held low in a high phase that follows at least one falling edge makes the block release both wires at once. It then pulses `frame_abort` for one cycle and returns to ready without pulsing `frame_done`.
- R8: A clock wire held low before the first falling edge gives no abort. The block releases the data wire, keeps the byte, holds `tx_ready` at 0, and sends the same byte in full once the wire is released.
- R9: A clock wire held low after the eleventh falling edge gives no abort, and `frame_done` still pulses.
- R10: A byte is taken only when `tx_valid` and `tx_ready` are both 1. While a frame is in progress `tx_ready` is 0, and `tx_valid`/`tx_byte` have no effect on the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_in | input | 1 | Sensed level of the bus clock wire |
| tx_valid | input | 1 | Queue offers a byte |
| tx_byte | input | 8 | Byte to send |
| tx_ready | output | 1 | Block is idle and will take a byte |
| ps2_clk_drv | output | 1 | 1 pulls the clock wire low |
| ps2_dat_drv | output | 1 | 1 pulls the data wire low |
| frame_done | output | 1 | One-cycle pulse: frame delivered |
| frame_abort | output | 1 | One-cycle pulse: frame cut, resend the chunk |

## Verification
The hardest situation to reach from the ports is a host clamp that falls inside a chosen clock phase of a chosen bit. Examples are the start bit's high phase, after the start bit is on the wire but before any falling edge, or the final low phase. The bench watches the two wires itself and counts falling edges and cycles within each phase. It raises its host-clamp signal only once it has seen a given number of edges or the start bit appear. That places each inhibit on a known side of the retransmit boundary.

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx #(
  parameter int TICK_CYC = 100,
  parameter int HALF_US  = 40,
  parameter int DATA_US  = 20,
  parameter int GUARD_US = 50,
  parameter int SYNC_LAT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_in,
  input  logic       tx_valid,
  input  logic [7:0] tx_byte,
  output logic       tx_ready,
  output logic       ps2_clk_drv,
  output logic       ps2_dat_drv,
  output logic       frame_done,
  output logic       frame_abort
);

  localparam int HALF_CYC  = HALF_US * TICK_CYC;
  localparam int DATA_CYC  = DATA_US * TICK_CYC;
  localparam int GUARD_CYC = GUARD_US * TICK_CYC;
  localparam int MAX_CYC   = (GUARD_CYC > HALF_CYC) ? GUARD_CYC : HALF_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1) + 1;
  localparam int NBITS     = 11;

  typedef enum logic [1:0] {S_IDLE, S_GUARD, S_HIGH, S_LOW} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [10:0]   sr;
  logic [3:0]    idx;
  logic [1:0]    sync;
  logic          dat_q, done_q, abort_q;

  wire clk_s   = sync[1];
  wire inhibit = (st == S_HIGH) && (cnt >= CW'(SYNC_LAT)) && !clk_s;

  assign tx_ready    = (st == S_IDLE);
  assign ps2_clk_drv = (st == S_LOW);
  assign ps2_dat_drv = dat_q;
  assign frame_done  = done_q;
  assign frame_abort = abort_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sr      <= '1;
      idx     <= '0;
      sync    <= '0;
      dat_q   <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      sync    <= {sync[0], ps2_clk_in};
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (tx_valid) begin
            sr  <= {1'b1, ~^tx_byte, tx_byte, 1'b0};
            idx <= '0;
            cnt <= '0;
            st  <= S_GUARD;
          end
        end
        S_GUARD: begin
          dat_q <= 1'b0;
          if (!clk_s) cnt <= '0;
          else if (cnt == CW'(GUARD_CYC - 1)) begin
            cnt <= '0;
            st  <= S_HIGH;
          end else cnt <= cnt + 1'b1;
        end
        S_HIGH: begin
          if (inhibit) begin
            cnt   <= '0;
            dat_q <= 1'b0;
            if (idx == '0) st <= S_GUARD;
            else begin
              st      <= S_IDLE;
              abort_q <= 1'b1;
            end
          end else begin
            if (cnt == CW'(DATA_CYC - 1)) dat_q <= ~sr[0];
            if (cnt == CW'(HALF_CYC - 1)) begin
              cnt <= '0;
              st  <= S_LOW;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_LOW: begin
          if (cnt == CW'(HALF_CYC - 1)) begin
            cnt <= '0;
            if (idx == 4'(NBITS - 1)) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
              dat_q  <= 1'b0;
            end else begin
              idx <= idx + 1'b1;
              sr  <= {1'b1, sr[10:1]};
              st  <= S_HIGH;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else        low_run <= ps2_clk_drv ? low_run + 1'b1 : '0;
  end

  AST_LOW_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ps2_clk_drv |-> (low_run < CW'(HALF_CYC))); // R3
  AST_DATA_STABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ps2_clk_drv && $past(ps2_clk_drv)) |-> $stable(ps2_dat_drv)); // R4
  AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps2_clk_drv) |-> $past(clk_s)); // R2
  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |-> (!ps2_clk_drv && !ps2_dat_drv && tx_ready)); // R7
  AST_DONE_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_abort)); // R6
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && tx_valid) |=> !tx_ready); // R10

endmodule

// File: tb/ps2_dev_tx_test.sv
module ps2_dev_tx_test;
  localparam int TICK = 1;
  localparam int HALF = 40;
  localparam int DAT  = 20;
  localparam int GRD  = 50;

  logic clk = 0, rst_n = 0, tx_valid = 0, host_hold = 0;
  logic [7:0] tx_byte = 0;
  logic tx_ready, drv_c, drv_d, frame_done, frame_abort;
  wire clk_line = !(drv_c || host_hold);
  wire dat_line = !drv_d;

  ps2_dev_tx #(.TICK_CYC(TICK), .HALF_US(HALF), .DATA_US(DAT), .GUARD_US(GRD)) uut (
    .clk(clk), .rst_n(rst_n), .ps2_clk_in(clk_line), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .tx_ready(tx_ready), .ps2_clk_drv(drv_c),
    .ps2_dat_drv(drv_d), .frame_done(frame_done), .frame_abort(frame_abort));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int done_cnt = 0, abort_cnt = 0, tbad = 0, fc = 0;
  int low_run = 0, high_run = 0;
  logic counted = 0, prev_c = 1, prev_d = 1;
  logic [10:0] cap = 0;

  typedef struct packed { logic [7:0] b; logic [10:0] f; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'h00, 11'h600}, '{8'hFF, 11'h7FE}, '{8'hA5, 11'h74A},
    '{8'h01, 11'h402}, '{8'h80, 11'h500}, '{8'h3C, 11'h678}};

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      summary();
    end
    if (frame_done) done_cnt++;
    if (frame_abort) abort_cnt++;
    if (prev_c && !clk_line) begin
      if (!host_hold) begin
        if (fc > 0 && high_run != HALF * TICK) tbad++;
        if (fc < 11) cap[fc] = dat_line;
        fc++;
        counted = 1;
      end else counted = 0;
      low_run = 1;
    end else if (!clk_line) low_run++;
    if (!prev_c && clk_line) begin
      if (counted && low_run != HALF * TICK) tbad++;
      high_run = 1;
    end else if (clk_line) high_run++;
    if (host_hold) counted = 0;
    if (dat_line != prev_d && clk_line && prev_c && fc > 0 && fc < 11 && high_run != DAT * TICK + 1) tbad++;
    if (dat_line != prev_d && !clk_line) tbad++;
    prev_c = clk_line;
    prev_d = dat_line;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    fc = 0; cap = 0; tbad = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    tx_byte = b; tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic wait_end(input int d0, input int a0);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done_cnt != d0 || abort_cnt != a0) break;
    end
  endtask

  task automatic wait_fc(input int n);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (fc >= n) break;
    end
  endtask

  initial begin
    int d0, a0, t0;
    repeat (3) @(negedge clk);
    chk(!drv_c && !drv_d, "R1 lines released", {drv_c, drv_d}, 0);
    chk(tx_ready && !frame_done && !frame_abort, "R1 ready/strobes", {tx_ready, frame_done, frame_abort}, 3'b100);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(tx_ready && !drv_c && !drv_d, "R1 after release", {tx_ready, drv_c, drv_d}, 3'b100);

    foreach (VECS[k]) begin
      mon_clear(); d0 = done_cnt; a0 = abort_cnt;
      push(VECS[k].b);
      wait_end(d0, a0);
      @(negedge clk);
      chk(cap == VECS[k].f, "R5 frame bits", cap, VECS[k].f);
      chk(done_cnt == d0 + 1 && abort_cnt == a0, "R6 one done pulse", done_cnt - d0, 1);
      chk(tbad == 0, "R3 R4 phase timing", tbad, 0);
      chk(tx_ready && !drv_c && !drv_d, "R6 idle after frame", {tx_ready, drv_c, drv_d}, 3'b100);
    end

    mon_clear(); d0 = done_cnt;
    host_hold = 1;
    push(8'h5A);
    repeat (100) @(negedge clk);
    chk(fc == 0 && !drv_d && !drv_c, "R2 held off while inhibited", fc, 0);
    host_hold = 0; repeat (30) @(negedge clk);
    host_hold = 1; repeat (20) @(negedge clk);
    chk(fc == 0, "R2 short release restarts wait", fc, 0);
    host_hold = 0; t0 = cyc;
    wait_fc(1);
    chk((cyc - t0) >= (GRD + HALF) * TICK && (cyc - t0) <= (GRD + HALF) * TICK + 4,
        "R2 first edge delay", cyc - t0, (GRD + HALF) * TICK);
    wait_end(d0, abort_cnt);
    @(negedge clk);
    chk(cap == 11'h6B4, "R2 R5 frame after guard", cap, 11'h6B4);

    mon_clear(); d0 = done_cnt;
    push(8'hC3);
    repeat (200) @(negedge clk);
    chk(!tx_ready, "R10 busy during frame", tx_ready, 0);
    tx_byte = 8'h55; tx_valid = 1;
    repeat (50) @(negedge clk);
    tx_valid = 0;
    wait_end(d0, abort_cnt);
    @(negedge clk);
    chk(cap == 11'h786, "R10 busy offer ignored", cap, 11'h786);

    mon_clear(); d0 = done_cnt; a0 = abort_cnt;
    push(8'h96);
    wait_fc(3);
    while (!clk_line) @(negedge clk);
    repeat (10) @(negedge clk);
    host_hold = 1;
    wait_end(d0, a0);
    @(negedge clk);
    chk(abort_cnt == a0 + 1 && done_cnt == d0, "R7 abort pulse", abort_cnt - a0, 1);
    chk(!drv_c && !drv_d && tx_ready, "R7 lines released", {drv_c, drv_d, tx_ready}, 3'b001);
    host_hold = 0;
    repeat (300) @(negedge clk);
    chk(fc == 3 && !drv_c, "R7 no resume after abort", fc, 3);

    mon_clear(); d0 = done_cnt; a0 = abort_cnt;
    push(8'h0F);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!dat_line) break;
    end
    repeat (5) @(negedge clk);
    host_hold = 1;
    repeat (20) @(negedge clk);
    chk(abort_cnt == a0 && !drv_d && !tx_ready, "R8 quiet inhibit", {abort_cnt - a0, drv_d, tx_ready}, 0);
    host_hold = 0;
    wait_end(d0, a0);
    @(negedge clk);
    chk(cap == 11'h61E && abort_cnt == a0 && done_cnt == d0 + 1, "R8 same byte resent", cap, 11'h61E);

    mon_clear(); d0 = done_cnt; a0 = abort_cnt;
    push(8'h81);
    wait_fc(11);
    host_hold = 1;
    wait_end(d0, a0);
    @(negedge clk);
    chk(done_cnt == d0 + 1 && abort_cnt == a0, "R9 late inhibit no abort", abort_cnt - a0, 0);
    chk(cap == 11'h702, "R9 R5 frame bits", cap, 11'h702);
    repeat (50) @(negedge clk);
    host_hold = 0;
    repeat (20) @(negedge clk);
    chk(tx_ready && !drv_c && !drv_d, "R9 idle", {tx_ready, drv_c, drv_d}, 3'b100);

    summary();
  end
endmodule